// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

A memory-mapped watchdog peripheral with five 16-bit registers: control, service, reset cause, interrupt control and miscellaneous control. Software programs a timeout in half-second ticks and sets the enable bit. The block then counts down on a slow tick enable supplied by the surrounding clock divider. If software does not service it in time, the block records a timeout cause and emits a one-cycle reset-request pulse. Software services the watchdog by writing a two-word key sequence to the service register.

An optional second down-counter raises an interrupt a programmable number of ticks before expiry. Software clears that interrupt by writing 1 to its status bit. Some fields are protective. The enable bit can be set but never cleared. The timeout field is write-once. The interrupt enable and pre-timeout value are write-once. The control register can also request a software reset directly. Reads are combinational on the same cycle as the request.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the registers read as follows: control 0x0030 (bit 5 = reset-assert-n, bit 4 = software-reset-n), service 0x0000, cause 0x0000, interrupt control 0x0004, miscellaneous 0x0001. irq_o and rst_req_o are low.
- R2: The main counter runs only while enable (control bit 2) is 1 and the timeout field (control bits [15:8]) is nonzero. It loads timeout+1 ticks. The tick that reaches zero sets the cause register to 0x0002 and drives rst_req_o high for exactly one cycle on the following clock.
- R3: A service write to offset 0x2 with value 0xAAAA reloads the main counter with timeout+1, but only when the previous service write was 0x5555. Any other order does not reload the counter. The service register reads back the last value written.
- R4: Once enable has been written to 1, later control writes with enable 0 leave it at 1.
- R5: The first control write fixes the timeout field. Later control writes leave it unchanged.
- R6: A control write with software-reset-n (bit 4) at 0 sets the cause register to 0x0001 and pulses rst_req_o on the next clock. This holds whatever the value of bit 5. Bit 4 always reads back as 1.
- R7: A control write whose resulting enable is 1 and whose resulting timeout is 0 pulses rst_req_o on the next clock.
- R8: Every control write restarts the main counter from timeout+1.
- R9: While the interrupt is enabled (interrupt control bit 15), the pre-timeout counter is loaded with (main count − pre-timeout value in bits [7:0]). It is started only if the main count is strictly greater than the pre-timeout value. When it reaches zero, status bit 14 and irq_o go high on the next clock.
- R10: Writing 1 to interrupt-control bit 14 clears the status bit and irq_o. The first interrupt-control write fixes bit 15 and bits [7:0].
- R11: Writes to the cause register (0x4) have no effect. Miscellaneous bit 0 is writable. Offsets other than 0x0, 0x2, 0x4, 0x6 and 0x8 read as 0.
- R12: rdata_o carries the addressed register in the same cycle that req_i is high with we_i low. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Half-second tick enable, one cycle wide |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Byte offset of the 16-bit register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Pre-timeout interrupt, level |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
Read data is due in the same cycle as the request. The interrupt and the reset request are due one clock after the tick or write that causes them. Register state changes on the write's own clock edge. The bench drives inputs shortly after each rising edge and evaluates every output at the falling edge. A behavioural reference, updated on each rising edge, therefore predicts exactly the value present at that sample point. Hand-computed checks are placed with margins of whole tick periods, so a tick phase cannot move a result across the sample.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DW     = 16;
  localparam int unsigned AW     = 4;
  localparam int unsigned TO_W   = 8;
  localparam int unsigned TO_LSB = 8;
  localparam int unsigned PRE_W  = 8;
  localparam int unsigned CNT_W  = TO_W + 1;

  localparam logic [AW-1:0] OFF_CTL   = 4'h0;
  localparam logic [AW-1:0] OFF_SVC   = 4'h2;
  localparam logic [AW-1:0] OFF_CAUSE = 4'h4;
  localparam logic [AW-1:0] OFF_ICR   = 4'h6;
  localparam logic [AW-1:0] OFF_MISC  = 4'h8;

  localparam int unsigned CTL_EN    = 2;
  localparam int unsigned CTL_SRS_N = 4;
  localparam int unsigned CTL_RA_N  = 5;
  localparam int unsigned ICR_IEN   = 15;
  localparam int unsigned ICR_STS   = 14;
  localparam int unsigned MISC_PDE  = 0;
  localparam int unsigned CAUSE_SW  = 0;
  localparam int unsigned CAUSE_TO  = 1;

  localparam logic [DW-1:0] SVC_KEY_A = 16'h5555;
  localparam logic [DW-1:0] SVC_KEY_B = 16'hAAAA;
endpackage

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic         start_i,
  input  logic [W-1:0] load_val_i,
  input  logic         stop_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= start_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - W'(1);
      if (cnt_q == W'(1)) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign exp_o = tick_i && run_q && (cnt_q == W'(1)) && !load_i && !stop_i;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs import wdog_pkg::*; #(
  parameter logic [PRE_W-1:0] PRE_DEFAULT = 8'd4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             main_exp_i,
  input  logic             pre_exp_i,
  output logic [DW-1:0]    rdata_o,
  output logic [TO_W-1:0]  timeout_o,
  output logic             en_o,
  output logic             ien_o,
  output logic [PRE_W-1:0] pre_o,
  output logic             ctl_wr_o,
  output logic             icr_wr_o,
  output logic             svc_ok_o,
  output logic             sw_req_o,
  output logic             irq_o
);
  logic [TO_W-1:0]  to_q;
  logic             en_q, ra_n_q, ctl_lock_q;
  logic [DW-1:0]    svc_q;
  logic [1:0]       cause_q;
  logic             ien_q, sts_q, icr_lock_q, pde_q;
  logic [PRE_W-1:0] pre_q;

  logic wr, wr_ctl, wr_svc, wr_icr, wr_misc;
  assign wr      = req_i && we_i;
  assign wr_ctl  = wr && (addr_i == OFF_CTL);
  assign wr_svc  = wr && (addr_i == OFF_SVC);
  assign wr_icr  = wr && (addr_i == OFF_ICR);
  assign wr_misc = wr && (addr_i == OFF_MISC);

  // values in effect this cycle, including a write in progress
  assign timeout_o = (wr_ctl && !ctl_lock_q) ? wdata_i[TO_LSB +: TO_W] : to_q;
  assign en_o      = en_q || (wr_ctl && wdata_i[CTL_EN]);
  assign ien_o     = (wr_icr && !icr_lock_q) ? wdata_i[ICR_IEN] : ien_q;
  assign pre_o     = (wr_icr && !icr_lock_q) ? wdata_i[PRE_W-1:0] : pre_q;

  assign ctl_wr_o = wr_ctl;
  assign icr_wr_o = wr_icr;
  assign svc_ok_o = wr_svc && (svc_q == SVC_KEY_A) && (wdata_i == SVC_KEY_B);
  assign sw_req_o = wr_ctl && !wdata_i[CTL_SRS_N];
  assign irq_o    = sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q       <= '0;
      en_q       <= 1'b0;
      ra_n_q     <= 1'b1;
      ctl_lock_q <= 1'b0;
    end else if (wr_ctl) begin
      to_q       <= timeout_o;
      en_q       <= en_o;
      ra_n_q     <= wdata_i[CTL_RA_N];
      ctl_lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= '0;
    else if (wr_svc) svc_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (main_exp_i && en_q) begin
      cause_q <= '0;
      cause_q[CAUSE_TO] <= 1'b1;
    end else if (sw_req_o) begin
      cause_q <= '0;
      cause_q[CAUSE_SW] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q      <= 1'b0;
      pre_q      <= PRE_DEFAULT;
      icr_lock_q <= 1'b0;
    end else if (wr_icr) begin
      ien_q      <= ien_o;
      pre_q      <= pre_o;
      icr_lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else if (pre_exp_i) sts_q <= 1'b1;
    else if (wr_icr && wdata_i[ICR_STS]) sts_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pde_q <= 1'b1;
    else if (wr_misc) pde_q <= wdata_i[MISC_PDE];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        OFF_CTL: begin
          rdata_o[TO_LSB +: TO_W] = to_q;
          rdata_o[CTL_RA_N]       = ra_n_q;
          rdata_o[CTL_SRS_N]      = 1'b1;
          rdata_o[CTL_EN]         = en_q;
        end
        OFF_SVC:   rdata_o = svc_q;
        OFF_CAUSE: rdata_o[1:0] = cause_q;
        OFF_ICR: begin
          rdata_o[ICR_IEN]     = ien_q;
          rdata_o[ICR_STS]     = sts_q;
          rdata_o[PRE_W-1:0]   = pre_q;
        end
        OFF_MISC:  rdata_o[MISC_PDE] = pde_q;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer import wdog_pkg::*; #(
  parameter logic [PRE_W-1:0] PRE_DEFAULT = 8'd4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic [TO_W-1:0]  timeout_eff;
  logic [PRE_W-1:0] pre_eff;
  logic             en_eff, ien_eff, ctl_wr, icr_wr, svc_ok, sw_req;
  logic             main_exp, pre_exp, main_run, pre_run;
  logic [CNT_W-1:0] main_cnt, pre_cnt;

  wdog_regs #(.PRE_DEFAULT(PRE_DEFAULT)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .main_exp_i (main_exp),
    .pre_exp_i  (pre_exp),
    .rdata_o,
    .timeout_o  (timeout_eff),
    .en_o       (en_eff),
    .ien_o      (ien_eff),
    .pre_o      (pre_eff),
    .ctl_wr_o   (ctl_wr),
    .icr_wr_o   (icr_wr),
    .svc_ok_o   (svc_ok),
    .sw_req_o   (sw_req),
    .irq_o
  );

  logic             running, reload_gt, cur_gt;
  logic [CNT_W-1:0] reload_val, pre_ext;
  assign running    = en_eff && (timeout_eff != '0);
  assign reload_val = CNT_W'(timeout_eff) + CNT_W'(1);
  assign pre_ext    = CNT_W'(pre_eff);
  assign reload_gt  = reload_val > pre_ext;
  assign cur_gt     = main_cnt > pre_ext;

  logic m_load, m_start;
  assign m_load  = ctl_wr || (svc_ok && running);
  assign m_start = ctl_wr ? running : main_run;

  wdog_down_cnt #(.W(CNT_W)) u_main_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i     (m_load),
    .start_i    (m_start),
    .load_val_i (reload_val),
    .stop_i     (1'b0),
    .cnt_o      (main_cnt),
    .run_o      (main_run),
    .exp_o      (main_exp)
  );

  logic             p_load, p_start, p_stop;
  logic [CNT_W-1:0] p_val;
  always_comb begin
    p_load  = 1'b0;
    p_start = 1'b0;
    p_stop  = 1'b0;
    p_val   = reload_val - pre_ext;
    if (ctl_wr) begin
      if (running && ien_eff && reload_gt) begin
        p_load  = 1'b1;
        p_start = 1'b1;
      end else p_stop = 1'b1;
    end else if (icr_wr) begin
      p_val = main_cnt - pre_ext;
      if (running && ien_eff && cur_gt) begin
        p_load  = 1'b1;
        p_start = 1'b1;
      end else p_stop = 1'b1;
    end else if (svc_ok) begin
      // reload keeps the pre counter's run state
      if (!ien_eff) p_stop = 1'b1;
      else if (running && reload_gt) begin
        p_load  = 1'b1;
        p_start = pre_run;
      end
    end
  end

  wdog_down_cnt #(.W(CNT_W)) u_pre_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i     (p_load),
    .start_i    (p_start),
    .load_val_i (p_val),
    .stop_i     (p_stop),
    .cnt_o      (pre_cnt),
    .run_o      (pre_run),
    .exp_o      (pre_exp)
  );

  logic rst_req_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else rst_req_q <= sw_req
                   || (ctl_wr && en_eff && (timeout_eff == '0))
                   || (main_exp && en_eff);
  end
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk import wdog_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            irq_o,
  input logic            rst_req_o,
  input logic            main_exp_i,
  input logic            pre_exp_i,
  input logic            en_eff_i,
  input logic [TO_W-1:0] timeout_eff_i
);
  logic ctl_w, icr_w;
  assign ctl_w = req_i && we_i && (addr_i == OFF_CTL);
  assign icr_w = req_i && we_i && (addr_i == OFF_ICR);

  // R2
  expiry_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_exp_i && en_eff_i) |=> rst_req_o);
  // R4
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_eff_i |=> en_eff_i);
  // R5
  timeout_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_w |=> (timeout_eff_i == $past(timeout_eff_i)));
  // R6
  sw_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && !wdata_i[CTL_SRS_N]) |=> rst_req_o);
  // R7
  imm_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && en_eff_i && (timeout_eff_i == '0)) |=> rst_req_o);
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(pre_exp_i));
  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icr_w && wdata_i[ICR_STS] && !pre_exp_i) |=> !irq_o);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .irq_o         (irq_o),
  .rst_req_o     (rst_req_o),
  .main_exp_i    (main_exp),
  .pre_exp_i     (pre_exp),
  .en_eff_i      (en_eff),
  .timeout_eff_i (timeout_eff)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int WDOG_LIMIT = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, rst_req_o;

  wdog_timer dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    n_vec = 0, n_fail = 0, rst_seen = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  always @(posedge clk_i) begin
    cyc++;
    #2 tick_i = (cyc % TICK_DIV == 0);
  end

  // behavioural reference
  int m_to, m_en, m_ra, m_clk, m_svc, m_cause, m_ien, m_pre, m_sts, m_ilk, m_pde;
  int m_cnt, m_run, m_icnt, m_irun, m_req;

  task automatic m_reset();
    m_to = 0; m_en = 0; m_ra = 1; m_clk = 0; m_svc = 0; m_cause = 0;
    m_ien = 0; m_pre = 4; m_sts = 0; m_ilk = 0; m_pde = 1;
    m_cnt = 0; m_run = 0; m_icnt = 0; m_irun = 0; m_req = 0;
  endtask

  task automatic m_step();
    bit w_ctl, w_svc, w_icr, w_misc, run_cfg, ok, mexp, pexp, ptouch;
    int to_e, en_e, ien_e, pre_e, rl, nc, nr, pc, pr;
    w_ctl  = req_i && we_i && addr_i == 4'h0;
    w_svc  = req_i && we_i && addr_i == 4'h2;
    w_icr  = req_i && we_i && addr_i == 4'h6;
    w_misc = req_i && we_i && addr_i == 4'h8;
    to_e = m_to; en_e = m_en; ien_e = m_ien; pre_e = m_pre;
    if (w_ctl) begin
      if (!m_clk) to_e = int'(wdata_i[15:8]);
      if (wdata_i[2]) en_e = 1;
    end
    if (w_icr && !m_ilk) begin
      ien_e = int'(wdata_i[15]);
      pre_e = int'(wdata_i[7:0]);
    end
    run_cfg = (en_e != 0) && (to_e != 0);
    rl = to_e + 1;
    ok = w_svc && m_svc == 16'h5555 && wdata_i == 16'hAAAA;
    nc = m_cnt; nr = m_run; mexp = 0;
    if (w_ctl) begin nc = rl; nr = run_cfg; end
    else if (ok && run_cfg) nc = rl;
    else if (tick_i && m_run != 0) begin
      nc = m_cnt - 1;
      if (m_cnt == 1) begin nr = 0; mexp = 1; end
    end
    pc = m_icnt; pr = m_irun; pexp = 0; ptouch = 0;
    if (w_ctl) begin
      ptouch = 1;
      if (run_cfg && ien_e != 0 && rl > pre_e) begin pc = rl - pre_e; pr = 1; end
      else pr = 0;
    end else if (w_icr) begin
      ptouch = 1;
      if (run_cfg && ien_e != 0 && m_cnt > pre_e) begin pc = m_cnt - pre_e; pr = 1; end
      else pr = 0;
    end else if (ok) begin
      if (ien_e == 0) begin ptouch = 1; pr = 0; end
      else if (run_cfg && rl > pre_e) begin ptouch = 1; pc = rl - pre_e; end
    end
    if (!ptouch && tick_i && m_irun != 0) begin
      pc = m_icnt - 1;
      if (m_icnt == 1) begin pr = 0; pexp = 1; end
    end
    m_req = ((w_ctl && !wdata_i[4]) || (w_ctl && en_e != 0 && to_e == 0) || mexp) ? 1 : 0;
    if (mexp) m_cause = 2;
    else if (w_ctl && !wdata_i[4]) m_cause = 1;
    if (pexp) m_sts = 1;
    else if (w_icr && wdata_i[14]) m_sts = 0;
    if (w_ctl) begin m_ra = int'(wdata_i[5]); m_clk = 1; end
    if (w_icr) m_ilk = 1;
    if (w_svc) m_svc = int'(wdata_i);
    if (w_misc) m_pde = int'(wdata_i[0]);
    m_to = to_e; m_en = en_e; m_ien = ien_e; m_pre = pre_e;
    m_cnt = nc; m_run = nr; m_icnt = pc; m_irun = pr;
  endtask

  function automatic int m_read();
    if (!(req_i && !we_i)) return 0;
    case (addr_i)
      4'h0: return (m_to << 8) | (m_ra << 5) | 16 | (m_en << 2);
      4'h2: return m_svc;
      4'h4: return m_cause;
      4'h6: return (m_ien << 15) | (m_sts << 14) | m_pre;
      4'h8: return m_pde;
      default: return 0;
    endcase
  endfunction

  initial m_reset();
  always @(posedge clk_i) begin
    if (!rst_ni) m_reset();
    else m_step();
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_vec++;
      if (irq_o !== (m_sts != 0)) begin
        n_fail++;
        $display("FAIL %s irq_o act=%0d exp=%0d", cur_req, irq_o, m_sts);
      end
      if (rst_req_o !== (m_req != 0)) begin
        n_fail++;
        $display("FAIL %s rst_req_o act=%0d exp=%0d", cur_req, rst_req_o, m_req);
      end
      if (int'(rdata_o) != m_read()) begin
        n_fail++;
        $display("FAIL %s rdata_o act=%h exp=%h", cur_req, rdata_o, m_read());
      end
      if (rst_req_o) rst_seen++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk_i); #2;
    req_i = 0; we_i = 0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(posedge clk_i); #2;
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    idle();
  endtask

  task automatic rd(logic [3:0] a, int exp, string tag);
    @(posedge clk_i); #2;
    req_i = 1; we_i = 0; addr_i = a; wdata_i = '0;
    @(negedge clk_i);
    chk(tag, int'(rdata_o), exp);
    idle();
  endtask

  task automatic do_reset();
    @(posedge clk_i); #2;
    rst_ni = 0; req_i = 0; we_i = 0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    if (cyc > WDOG_LIMIT && !done) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, WDOG_LIMIT);
      finish_run();
    end
  end

  initial begin
    int base;
    do_reset();
    // R1 / R12: reset values, same-cycle read
    cur_req = "R1";
    rd(4'h0, 'h0030, "R1 ctl");
    rd(4'h2, 'h0000, "R1 svc");
    rd(4'h4, 'h0000, "R1 cause");
    rd(4'h6, 'h0004, "R1 icr");
    rd(4'h8, 'h0001, "R12 misc");
    chk("R1 irq", int'(irq_o), 0);

    // R2: timeout 3 -> expiry within 4 ticks
    cur_req = "R2";
    base = rst_seen;
    wr(4'h0, 16'h0334);
    wait_cyc(20);
    chk("R2 pulses", rst_seen - base, 1);
    rd(4'h4, 'h0002, "R2 cause");

    // R4 / R5 / R8: locked timeout, sticky enable, restart
    cur_req = "R8";
    wr(4'h0, 16'h0730);
    rd(4'h0, 'h0334, "R5 R4 ctl locked");
    wait_cyc(20);
    chk("R8 restart pulse", rst_seen - base, 2);

    // R3: good service sequence keeps it alive
    do_reset();
    cur_req = "R3";
    base = rst_seen;
    wr(4'h0, 16'h0A34);
    for (int i = 0; i < 6; i++) begin
      wait_cyc(12);
      wr(4'h2, 16'h5555);
      wr(4'h2, 16'hAAAA);
    end
    chk("R3 serviced", rst_seen - base, 0);
    for (int i = 0; i < 4; i++) begin
      wait_cyc(12);
      wr(4'h2, 16'h5555);
      wr(4'h2, 16'h1234);
      wr(4'h2, 16'hAAAA);
    end
    chk("R3 broken sequence", rst_seen - base, 1);
    rd(4'h2, 'hAAAA, "R3 svc readback");

    // R6: software reset request
    do_reset();
    cur_req = "R6";
    base = rst_seen;
    wr(4'h0, 16'h0020);
    wait_cyc(30);
    chk("R6 sw pulse", rst_seen - base, 1);
    rd(4'h4, 'h0001, "R6 cause");
    rd(4'h0, 'h0030, "R6 srs reads 1");
    wr(4'h4, 16'h0000);
    wr(4'h0, 16'h0000);
    wait_cyc(2);
    chk("R6 both low", rst_seen - base, 2);

    // R7: enable with zero timeout
    do_reset();
    cur_req = "R7";
    base = rst_seen;
    wr(4'h0, 16'h0014);
    wait_cyc(2);
    chk("R7 immediate", rst_seen - base, 1);
    rd(4'h4, 'h0000, "R7 cause");

    // R9 / R10: pre-timeout
    do_reset();
    cur_req = "R9";
    base = rst_seen;
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0534);
    wait_cyc(12);
    @(negedge clk_i);
    chk("R9 irq raised", int'(irq_o), 1);
    chk("R9 not expired", rst_seen - base, 0);
    cur_req = "R10";
    wr(4'h6, 16'h4000);
    @(negedge clk_i);
    chk("R10 irq cleared", int'(irq_o), 0);
    rd(4'h6, 'h8002, "R10 icr locked");
    wait_cyc(20);
    chk("R9 expiry after irq", rst_seen - base, 1);

    // R9: pre value not below count
    do_reset();
    base = rst_seen;
    cur_req = "R9";
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0134);
    wait_cyc(15);
    chk("R9 no irq", int'(irq_o), 0);
    chk("R9 expired", rst_seen - base, 1);

    // R11: read-only cause, misc, unmapped
    do_reset();
    cur_req = "R11";
    wr(4'h4, 16'hFFFF);
    rd(4'h4, 'h0000, "R11 cause ignored");
    wr(4'h8, 16'h0000);
    rd(4'h8, 'h0000, "R11 misc clear");
    wr(4'h8, 16'hFFFF);
    rd(4'h8, 'h0001, "R11 misc set");
    rd(4'hA, 'h0000, "R11 unmapped");
    chk("R12 no read", int'(rdata_o), 0);

    wait_cyc(4);
    finish_run();
  end
endmodule